// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Service

This block is a watchdog counter. It raises a one-cycle reset request unless software restarts it in time. To restart it, software writes a fixed pair of key bytes to a byte-wide service port. A configuration port takes effect only on its first write after reset. That write chooses three things:

- the count source, either a slow low-power tick qualified by an enable input or every bus clock;
- a two-bit period code, where zero switches the block off;
- whether windowed servicing applies.

In windowed operation with the bus clock as source, servicing is legal only in the last quarter of the period. Any write to the service port before that point is treated as a fault and raises the reset request at once.

The reset request is meant to feed the chip's reset controller. A synchronous active-high reset returns the block to its power-on configuration: slow source, longest period code, window off, count cleared, configuration unlocked.

Top module: `wdog_window`

## Requirements
- R1: A service write of 0x55 followed by a service write of 0xAA (the next service write, with idle cycles allowed between them) clears the count to zero, so the next overflow comes a full period after the 0xAA write.
- R2: A service write of any value other than 0xAA after 0x55 cancels the partial sequence. A lone 0xAA does not restart the count, and in normal mode neither case raises a request.
- R3: Period code 00 disables the block. It does not count, never raises the reset request, and ignores service writes.
- R4: With the slow source (select = 0), the count advances only on cycles where the tick enable is 1. Overflow comes after 32, 256 or 1024 ticks for codes 01, 10 and 11.
- R5: With the bus source (select = 1), the count advances on every cycle. Overflow comes after 8192, 65536 or 262144 cycles for codes 01, 10 and 11.
- R6: At overflow, the reset request is high for exactly the one cycle after the counting edge that reaches the limit, and the count restarts from zero.
- R7: In window mode with the bus source, a service write of any value while the count is below three quarters of the limit (6144 for code 01) raises the reset request in the next cycle and restarts the count. From that count onward, the key pair services the block normally.
- R8: In window mode with the slow source, the window has no effect, and an early key pair services the block as in normal mode.
- R9: Only the first configuration write after reset is taken. Later writes to source, period and window are ignored.
- R10: After reset the request is low, the count is zero, and the configuration is slow source, period code 11, window off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_tick | input | 1 | Slow-source count enable |
| cfg_we | input | 1 | Configuration write strobe (first one taken) |
| cfg_src | input | 1 | Source select: 0 slow tick, 1 bus clock |
| cfg_period | input | 2 | Period code, 00 disables |
| cfg_window | input | 1 | Windowed servicing enable |
| svc_we | input | 1 | Service register write strobe |
| svc_data | input | 8 | Service register write data |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The window boundary is probed on both sides. A write at count 6143 must fault and a write at count 6144 must not, so a design that compares off by one trips in only one of the two runs. Sequence corner cases are checked by overflow timing: a broken pair, a lone 0xAA and an idle gap inside the pair each shift the overflow edge if handled wrongly. The bench also repeats a configuration write with a different source and period to catch a lock that does not hold, and drives the slow tick at half rate to catch a counter that ignores the tick enable.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic {
        SRC_SLOW = 1'b0,
        SRC_BUS  = 1'b1
    } wd_src_e;

    typedef struct packed {
        wd_src_e    src;
        logic [1:0] period;
        logic       window;
    } wd_cfg_t;

    localparam wd_cfg_t CFG_POR = '{src: SRC_SLOW, period: 2'b11, window: 1'b0};

    // Exponent of the overflow count for a given configuration.
    function automatic int unsigned period_exp(
        input wd_cfg_t     c,
        input int unsigned s1, input int unsigned s2, input int unsigned s3,
        input int unsigned b1, input int unsigned b2, input int unsigned b3
    );
        int unsigned e;
        case (c.period)
            2'b01:   e = (c.src == SRC_BUS) ? b1 : s1;
            2'b10:   e = (c.src == SRC_BUS) ? b2 : s2;
            2'b11:   e = (c.src == SRC_BUS) ? b3 : s3;
            default: e = 0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import wdog_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  wd_cfg_t wdata,
    output wd_cfg_t cfg_q
);

    logic locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_POR;
            locked <= 1'b0;
        end else if (we && !locked) begin
            cfg_q  <= wdata;
            locked <= 1'b1;
        end
    end

    // R9: once locked, the configuration never moves again
    a_r9_locked_stable: assert property (@(posedge clk) disable iff (rst)
        (locked && $past(locked)) |-> $stable(cfg_q));

endmodule

// File: rtl/wdog_seq.sv
module wdog_seq #(
    parameter logic [7:0] KEY_ARM  = 8'h55,
    parameter logic [7:0] KEY_FIRE = 8'hAA
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       svc_we,
    input  logic [7:0] svc_data,
    input  logic       svc_ok,
    output logic       svc_done
);

    logic armed;

    assign svc_done = svc_we && svc_ok && armed && (svc_data == KEY_FIRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (svc_we) begin
            armed <= svc_ok && (svc_data == KEY_ARM);
        end
    end

    // R2: any write other than the arming key leaves the sequence unarmed
    a_r2_cancel: assert property (@(posedge clk) disable iff (rst)
        (svc_we && svc_data != KEY_ARM) |=> !armed);

endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  wd_cfg_t              cfg,
    input  logic [CNT_W:0]       limit,
    input  logic                 lp_tick,
    input  logic                 svc_we,
    input  logic                 svc_done,
    output logic                 svc_ok,
    output logic                 rst_req
);

    logic [CNT_W-1:0] count;
    logic [CNT_W:0]   count_x;
    logic [CNT_W:0]   open_at;
    logic             enabled;
    logic             tick;
    logic             win_on;
    logic             early;
    logic             fault;
    logic             at_limit;

    assign count_x  = {1'b0, count};
    assign open_at  = limit - (limit >> 2);
    assign enabled  = (cfg.period != 2'b00);
    assign tick     = enabled && ((cfg.src == SRC_BUS) || lp_tick);
    assign win_on   = enabled && cfg.window && (cfg.src == SRC_BUS);
    assign early    = win_on && (count_x < open_at);
    assign fault    = svc_we && early;
    assign svc_ok   = enabled && !early;
    assign at_limit = (count_x >= limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (fault) begin
                count   <= '0;
                rst_req <= 1'b1;
            end else if (svc_done) begin
                count <= '0;
            end else if (tick) begin
                if (at_limit) begin
                    count   <= '0;
                    rst_req <= 1'b1;
                end else begin
                    count <= count + 1'b1;
                end
            end
        end
    end

    // R3: a disabled block holds its count and never requests
    a_r3_idle: assert property (@(posedge clk) disable iff (rst)
        (!enabled && $past(!enabled)) |-> ($stable(count) && !rst_req));

    // R7: an early write in window mode faults and restarts
    a_r7_early_fault: assert property (@(posedge clk) disable iff (rst)
        (svc_we && win_on && count_x < open_at) |=> (rst_req && count == '0));

    // R1: a completed key pair clears the count without a request
    a_r1_restart: assert property (@(posedge clk) disable iff (rst)
        (svc_done && !fault) |=> (count == '0 && !rst_req));

endmodule

// File: rtl/wdog_window.sv
module wdog_window
    import wdog_pkg::*;
#(
    parameter int unsigned SLOW_E1  = 5,
    parameter int unsigned SLOW_E2  = 8,
    parameter int unsigned SLOW_E3  = 10,
    parameter int unsigned BUS_E1   = 13,
    parameter int unsigned BUS_E2   = 16,
    parameter int unsigned BUS_E3   = 18,
    parameter logic [7:0]  KEY_ARM  = 8'h55,
    parameter logic [7:0]  KEY_FIRE = 8'hAA
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lp_tick,
    input  logic       cfg_we,
    input  logic       cfg_src,
    input  logic [1:0] cfg_period,
    input  logic       cfg_window,
    input  logic       svc_we,
    input  logic [7:0] svc_data,
    output logic       rst_req
);

    localparam int unsigned CNT_W = BUS_E3;

    wd_cfg_t        cfg_wr;
    wd_cfg_t        cfg_cur;
    logic [CNT_W:0] limit;
    logic           svc_ok;
    logic           svc_done;

    always_comb begin
        cfg_wr.src    = wd_src_e'(cfg_src);
        cfg_wr.period = cfg_period;
        cfg_wr.window = cfg_window;
    end

    assign limit = (CNT_W+1)'(1) << period_exp(cfg_cur, SLOW_E1, SLOW_E2, SLOW_E3,
                                                BUS_E1, BUS_E2, BUS_E3);

    wdog_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wr),
        .cfg_q (cfg_cur)
    );

    wdog_seq #(
        .KEY_ARM  (KEY_ARM),
        .KEY_FIRE (KEY_FIRE)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .svc_we   (svc_we),
        .svc_data (svc_data),
        .svc_ok   (svc_ok),
        .svc_done (svc_done)
    );

    wdog_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg_cur),
        .limit    (limit),
        .lp_tick  (lp_tick),
        .svc_we   (svc_we),
        .svc_done (svc_done),
        .svc_ok   (svc_ok),
        .rst_req  (rst_req)
    );

endmodule

// File: tb/wdog_window_tb.sv
module wdog_window_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lp_tick = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_src = 1'b0;
    logic [1:0] cfg_period = 2'b00;
    logic       cfg_window = 1'b0;
    logic       svc_we = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       rst_req;

    int vectors = 0;
    int misses  = 0;
    int edge_k  = 0;
    int first_req = 0;
    logic lp_level = 1'b0;
    logic lp_half  = 1'b0;

    always #4 clk = ~clk;

    wdog_window u_dut (
        .clk        (clk),
        .rst        (rst),
        .lp_tick    (lp_tick),
        .cfg_we     (cfg_we),
        .cfg_src    (cfg_src),
        .cfg_period (cfg_period),
        .cfg_window (cfg_window),
        .svc_we     (svc_we),
        .svc_data   (svc_data),
        .rst_req    (rst_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [7:0] d);
        svc_we   = we;
        svc_data = d;
        lp_tick  = lp_half ? logic'(edge_k % 2) : lp_level;
        @(posedge clk);
        #2;
        edge_k++;
        if (rst_req && first_req == 0) first_req = edge_k;
        svc_we = 1'b0;
    endtask

    task automatic run_to(input int k);
        while (edge_k < k) step(1'b0, 8'h00);
    endtask

    task automatic run_until_req(input int maxk);
        while (first_req == 0 && edge_k < maxk) step(1'b0, 8'h00);
    endtask

    task automatic restart_meas();
        edge_k = 0;
        first_req = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1; lp_tick = 1'b0; lp_level = 1'b0; lp_half = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        rst = 1'b0;
        restart_meas();
    endtask

    task automatic cfg_write(input logic s, input logic [1:0] p, input logic w);
        cfg_we = 1'b1; cfg_src = s; cfg_period = p; cfg_window = w;
        lp_tick = 1'b0;
        @(posedge clk);
        #2;
        cfg_we = 1'b0;
        restart_meas();
    endtask

    task automatic t_reset_state();
        do_reset();
        check(rst_req == 1'b0, "R10 request low after reset", rst_req, 0);
        lp_level = 1'b1;
        run_until_req(1100);
        check(first_req == 1024, "R10 R4 default slow code 11 overflow", first_req, 1024);
    endtask

    task automatic t_slow_half();
        do_reset();
        cfg_write(1'b0, 2'b01, 1'b0);
        lp_half = 1'b1;
        run_until_req(200);
        check(first_req == 64, "R4 slow code 01 at half tick rate", first_req, 64);
        do_reset();
        cfg_write(1'b0, 2'b10, 1'b0);
        lp_level = 1'b1;
        run_until_req(300);
        check(first_req == 256, "R4 slow code 10", first_req, 256);
    endtask

    task automatic t_bus_period();
        do_reset();
        cfg_write(1'b1, 2'b01, 1'b0);
        run_until_req(9000);
        check(first_req == 8192, "R5 bus code 01 overflow", first_req, 8192);
        restart_meas();
        step(1'b0, 8'h00);
        check(rst_req == 1'b0, "R6 request lasts one cycle", rst_req, 0);
        run_until_req(9000);
        check(first_req == 8192, "R6 count restarts after overflow", first_req, 8192);
    endtask

    task automatic t_service();
        do_reset();
        cfg_write(1'b0, 2'b01, 1'b0);
        lp_level = 1'b1;
        run_to(9);
        step(1'b1, 8'h55);
        step(1'b0, 8'h00);
        step(1'b1, 8'hAA);
        run_until_req(100);
        check(first_req == 44, "R1 key pair with gap restarts count", first_req, 44);
    endtask

    task automatic t_bad_seq();
        do_reset();
        cfg_write(1'b0, 2'b01, 1'b0);
        lp_level = 1'b1;
        run_to(4);
        step(1'b1, 8'hAA);
        run_to(9);
        step(1'b1, 8'h55);
        step(1'b1, 8'h12);
        step(1'b1, 8'hAA);
        check(first_req == 0, "R2 no request from broken pair", first_req, 0);
        run_until_req(100);
        check(first_req == 32, "R2 broken pair and lone AA keep count", first_req, 32);
    endtask

    task automatic t_disabled();
        do_reset();
        cfg_write(1'b1, 2'b00, 1'b1);
        for (int i = 0; i < 50; i++) begin
            step(1'b1, 8'h55);
            step(1'b1, 8'hAA);
        end
        lp_level = 1'b1;
        run_to(2000);
        check(first_req == 0, "R3 disabled block never requests", first_req, 0);
    endtask

    task automatic t_write_once();
        do_reset();
        cfg_write(1'b1, 2'b01, 1'b0);
        cfg_we = 1'b1; cfg_src = 1'b0; cfg_period = 2'b11; cfg_window = 1'b1;
        step(1'b0, 8'h00);
        cfg_we = 1'b0;
        step(1'b1, 8'h55);
        check(first_req == 0, "R9 later window bit ignored", first_req, 0);
        run_until_req(9000);
        check(first_req == 8192, "R9 later source and period ignored", first_req, 8192);
    endtask

    task automatic t_window_early();
        do_reset();
        cfg_write(1'b1, 2'b01, 1'b1);
        run_to(6143);
        step(1'b1, 8'h55);
        check(first_req == 6144, "R7 write at count 6143 faults", first_req, 6144);
        restart_meas();
        run_until_req(9000);
        check(first_req == 8192, "R7 fault restarts count", first_req, 8192);
    endtask

    task automatic t_window_ok();
        do_reset();
        cfg_write(1'b1, 2'b01, 1'b1);
        run_to(6144);
        step(1'b1, 8'h55);
        step(1'b1, 8'hAA);
        check(first_req == 0, "R7 write at count 6144 accepted", first_req, 0);
        run_until_req(15000);
        check(first_req == 14338, "R7 in-window pair services", first_req, 14338);
    endtask

    task automatic t_window_slow();
        do_reset();
        cfg_write(1'b0, 2'b01, 1'b1);
        lp_level = 1'b1;
        run_to(2);
        step(1'b1, 8'h55);
        step(1'b1, 8'hAA);
        check(first_req == 0, "R8 early pair no fault on slow source", first_req, 0);
        run_until_req(100);
        check(first_req == 36, "R8 early pair services on slow source", first_req, 36);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        t_reset_state();
        t_slow_half();
        t_bus_period();
        t_service();
        t_bad_seq();
        t_disabled();
        t_write_once();
        t_window_early();
        t_window_ok();
        t_window_slow();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule